// File: doc/BRIEF.md
# Flash Special-Read Mode Controller

This block decides what a microcontroller bus read returns from a parallel nonvolatile memory. In its normal mode a read returns the byte stored in the main array. A three-write prefix (an unlock pair followed by a command byte) switches it into one of three special read modes. In those modes a read returns the device identifier, the protection flag of the addressed sector, or a byte from a separate 64-byte one-time-programmable row.

The identifier and protection modes answer one read and then fall back to normal mode. The one-time-programmable row mode persists across any number of reads until a return command is written. Within each special mode, fixed address bits and the select lines qualify the read. A read that fails this qualification returns zero. A small protection mask, loaded through a configuration strobe, supplies the per-sector flags. The main array and the row are modelled as read-only block memories with computed contents. Programming and erase are not part of this block.

Top module: `flash_sread_ctrl`

## Requirements
- R1: Reset leaves the block in normal mode with rd_valid at 0 and rd_data at 00h. A read (bus_re high, bus_we low) in normal mode returns array byte ((a mod 256)*37 + 11) mod 256, where a is the address. That byte appears on rd_data with rd_valid high on the second rising edge after the read is sampled.
- R2: The mode prefix has three writes: AAh to address 555h, 55h to address AAAh, then a command to 555h. Command 90h selects identifier mode, C2h selects protection mode and B8h selects row mode.
- R3: A prefix write whose address or data does not match aborts the prefix and returns the block to normal mode. A later read then returns the array byte.
- R4: In identifier mode a read returns E3h when address bit 6 is 0, bit 1 is 0, bit 0 is 1 and at least one flash_sel bit is high. Otherwise the read returns 00h.
- R5: In protection mode a read with address bit 6 = 0, bit 1 = 1 and bit 0 = 0 returns 01h when a selected sector has its mask bit set, and 00h when none does. A read with any other pattern of these bits returns 00h.
- R6: After one identifier or protection read, the block is in normal mode again, and the next read returns the array byte.
- R7: In row mode a read with address bit 6 = 0 and ee_sel high returns row byte ((j*5) mod 256) XOR A5h, where j is address bits 5..0. Any other read returns 00h. Reads do not leave row mode.
- R8: A write of F0h at any address and in any mode returns the block to normal mode. In row mode this is the only exit, and every other write is ignored.
- R9: A cfg_we pulse loads cfg_prot into the protection mask. Reset clears the mask.
- R10: Reset during a special mode returns the block to normal mode.
- R11: A read issued between prefix writes returns the array byte and does not break the prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read, ignored while bus_we is high |
| flash_sel | input | NSEC | Main-array sector selects, active high |
| ee_sel | input | 1 | Secondary-region select, active high, qualifies row reads |
| cfg_we | input | 1 | Loads the protection mask |
| cfg_prot | input | NSEC | New protection mask, one bit per sector |
| rd_data | output | 8 | Registered read result |
| rd_valid | output | 1 | High for one cycle when rd_data holds a read result |

## Verification
Every read result is due on the second rising edge after the read strobe is sampled. The first edge registers the source and the memory output, and the second edge registers the output mux. The bench raises the strobe at a falling edge, drops it at the next falling edge, and samples rd_data and rd_valid at the falling edge after that. Mode changes take effect on the edge that samples the write, so a read issued at the following falling edge already sees the new mode. Each check therefore compares a value that has settled for half a cycle.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [2:0] {
    M_NORM, M_UNL1, M_UNL2, M_ID, M_PROT, M_OTP
  } fsr_mode_e;

  typedef enum logic [1:0] {
    K_ARR, K_SPEC, K_OTP
  } fsr_kind_e;

  localparam logic [11:0] UNL_ADDR1 = 12'h555;
  localparam logic [11:0] UNL_ADDR2 = 12'hAAA;
  localparam logic [7:0]  UNL_DAT1  = 8'hAA;
  localparam logic [7:0]  UNL_DAT2  = 8'h55;
  localparam logic [7:0]  CMD_ID    = 8'h90;
  localparam logic [7:0]  CMD_PROT  = 8'hC2;
  localparam logic [7:0]  CMD_OTP   = 8'hB8;
  localparam logic [7:0]  CMD_RET   = 8'hF0;
  localparam logic [7:0]  DEV_ID    = 8'hE3;
endpackage

// File: rtl/fsr_seq_fsm.sv
module fsr_seq_fsm
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              we,
  input  logic              re,
  output fsr_mode_e         mode_o
);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(UNL_ADDR1);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(UNL_ADDR2);

  fsr_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (we) begin
      if (wdata == CMD_RET) begin
        mode_d = M_NORM;
      end else begin
        case (mode_q)
          M_NORM: if (addr == A1 && wdata == UNL_DAT1) mode_d = M_UNL1;
          M_UNL1: mode_d = (addr == A2 && wdata == UNL_DAT2) ? M_UNL2 : M_NORM;
          M_UNL2: begin
            mode_d = M_NORM;
            if (addr == A1) begin
              case (wdata)
                CMD_ID:   mode_d = M_ID;
                CMD_PROT: mode_d = M_PROT;
                CMD_OTP:  mode_d = M_OTP;
                default:  mode_d = M_NORM;
              endcase
            end
          end
          M_OTP:   mode_d = M_OTP;
          default: mode_d = M_NORM;
        endcase
      end
    end else if (re && (mode_q == M_ID || mode_q == M_PROT)) begin
      mode_d = M_NORM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= M_NORM;
    else     mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/fsr_rom.sv
module fsr_rom #(
  parameter int AW   = 8,
  parameter int MUL  = 1,
  parameter int ADD  = 0,
  parameter int XORV = 0
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [7:0]    q
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 8'(i * MUL + ADD) ^ 8'(XORV);
    end
  end

  always_ff @(posedge clk) begin
    q <= mem[addr];
  end
endmodule

// File: rtl/flash_sread_ctrl.sv
module flash_sread_ctrl
  import fsr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int ARR_AW    = 8,
  parameter int NSEC      = 8,
  parameter int OTP_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [NSEC-1:0]   flash_sel,
  input  logic              ee_sel,
  input  logic              cfg_we,
  input  logic [NSEC-1:0]   cfg_prot,
  output logic [7:0]        rd_data,
  output logic              rd_valid
);
  localparam int OTP_AW = $clog2(OTP_BYTES);
  localparam int QB     = OTP_AW;

  fsr_mode_e       mode_q;
  fsr_kind_e       kind_q;
  logic [NSEC-1:0] prot_q;
  logic [7:0]      spec_q, arr_q, otp_q, spec_d;
  logic            v1_q, rd_go;
  logic            id_ok, pr_ok, otp_ok;
  fsr_kind_e       kind_d;

  fsr_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .re(bus_re), .mode_o(mode_q)
  );

  fsr_rom #(.AW(ARR_AW), .MUL(37), .ADD(11), .XORV(0)) u_arr (
    .clk(clk), .addr(bus_addr[ARR_AW-1:0]), .q(arr_q)
  );

  fsr_rom #(.AW(OTP_AW), .MUL(5), .ADD(0), .XORV(8'hA5)) u_otp (
    .clk(clk), .addr(bus_addr[OTP_AW-1:0]), .q(otp_q)
  );

  always_ff @(posedge clk) begin
    if (rst)         prot_q <= '0;
    else if (cfg_we) prot_q <= cfg_prot;
  end

  assign rd_go  = bus_re && !bus_we;
  assign id_ok  = !bus_addr[QB] && !bus_addr[1] && bus_addr[0] && (|flash_sel);
  assign pr_ok  = !bus_addr[QB] && bus_addr[1] && !bus_addr[0] && (|flash_sel);
  assign otp_ok = !bus_addr[QB] && ee_sel;

  always_comb begin
    kind_d = K_ARR;
    spec_d = 8'h00;
    case (mode_q)
      M_ID: begin
        kind_d = K_SPEC;
        spec_d = id_ok ? DEV_ID : 8'h00;
      end
      M_PROT: begin
        kind_d = K_SPEC;
        spec_d = {7'b0, pr_ok && (|(flash_sel & prot_q))};
      end
      M_OTP: kind_d = otp_ok ? K_OTP : K_SPEC;
      default: kind_d = K_ARR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q   <= 1'b0;
      kind_q <= K_ARR;
      spec_q <= 8'h00;
    end else begin
      v1_q <= rd_go;
      if (rd_go) begin
        kind_q <= kind_d;
        spec_q <= spec_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= v1_q;
      if (v1_q) begin
        case (kind_q)
          K_ARR:   rd_data <= arr_q;
          K_OTP:   rd_data <= otp_q;
          default: rd_data <= spec_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/fsr_sread_chk.sv
module fsr_sread_chk
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NSEC   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [NSEC-1:0]   flash_sel,
  input logic [NSEC-1:0]   prot,
  input fsr_mode_e         mode,
  input logic [7:0]        rd_data,
  input logic              rd_valid
);
  a_r1_read_latency: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !bus_we) |=> ##1 rd_valid);

  a_r3_prefix_abort: assert property (@(posedge clk) disable iff (rst)
    (mode == M_UNL1 && bus_we &&
     !(bus_addr == ADDR_W'(UNL_ADDR2) && bus_wdata == UNL_DAT2)) |=> mode == M_NORM);

  a_r4_id_value: assert property (@(posedge clk) disable iff (rst)
    (mode == M_ID && bus_re && !bus_we && !bus_addr[6] && !bus_addr[1] &&
     bus_addr[0] && (|flash_sel)) |=> ##1 rd_data == DEV_ID);

  a_r5_unprot_zero: assert property (@(posedge clk) disable iff (rst)
    (mode == M_PROT && bus_re && !bus_we && ((flash_sel & prot) == '0))
    |=> ##1 rd_data == 8'h00);

  a_r6_single_shot: assert property (@(posedge clk) disable iff (rst)
    ((mode == M_ID || mode == M_PROT) && bus_re && !bus_we) |=> mode == M_NORM);

  a_r7_otp_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == M_OTP && !(bus_we && bus_wdata == CMD_RET)) |=> mode == M_OTP);
endmodule

bind flash_sread_ctrl fsr_sread_chk #(.ADDR_W(ADDR_W), .NSEC(NSEC)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .flash_sel(flash_sel), .prot(prot_q),
  .mode(mode_q), .rd_data(rd_data), .rd_valid(rd_valid)
);

// File: tb/tb_flash_sread_ctrl.sv
`timescale 1ns/1ps
module tb_flash_sread_ctrl;
  localparam int ADDR_W = 16;
  localparam int NSEC   = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0]        bus_wdata = '0;
  logic              bus_we = 1'b0;
  logic              bus_re = 1'b0;
  logic [NSEC-1:0]   flash_sel = '0;
  logic              ee_sel = 1'b0;
  logic              cfg_we = 1'b0;
  logic [NSEC-1:0]   cfg_prot = '0;
  logic [7:0]        rd_data;
  logic              rd_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  flash_sread_ctrl #(.ADDR_W(ADDR_W), .NSEC(NSEC)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .flash_sel(flash_sel), .ee_sel(ee_sel),
    .cfg_we(cfg_we), .cfg_prot(cfg_prot), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [7:0] arr_exp(int a);
    return 8'((a & 255) * 37 + 11);
  endfunction

  function automatic logic [7:0] otp_exp(int j);
    return 8'((j & 63) * 5) ^ 8'hA5;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(string tag, logic [ADDR_W-1:0] a, logic [NSEC-1:0] fs,
                    logic ee, logic [7:0] exp);
    @(negedge clk);
    bus_addr = a; flash_sel = fs; ee_sel = ee; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    @(negedge clk);
    check({tag, " valid"}, {7'b0, rd_valid}, 8'h01);
    check(tag, rd_data, exp);
  endtask

  task automatic unlock(logic [7:0] cmd);
    wr(16'h0555, 8'hAA);
    wr(16'h0AAA, 8'h55);
    wr(16'h0555, cmd);
  endtask

  task automatic pulse_rst();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset valid", {7'b0, rd_valid}, 8'h00);
    check("R1 reset data", rd_data, 8'h00);
  endtask

  task automatic t_normal();
    rd("R1 array 0000", 16'h0000, '0, 1'b0, arr_exp(0));
    rd("R1 array 00FF", 16'h00FF, '0, 1'b0, arr_exp(255));
    rd("R1 array 1234", 16'h1234, 8'h01, 1'b0, arr_exp(16'h1234));
  endtask

  task automatic t_ident();
    unlock(8'h90);
    rd("R2 R4 id", 16'h0001, 8'h01, 1'b0, 8'hE3);
    rd("R6 after id", 16'h0001, 8'h01, 1'b0, arr_exp(1));
    unlock(8'h90);
    rd("R4 id bit6 set", 16'h0041, 8'h01, 1'b0, 8'h00);
    unlock(8'h90);
    rd("R4 id no sel", 16'h0001, 8'h00, 1'b0, 8'h00);
  endtask

  task automatic t_prot();
    @(negedge clk); cfg_prot = 8'h04; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
    unlock(8'hC2);
    rd("R2 R5 R9 protected", 16'h0002, 8'h04, 1'b0, 8'h01);
    rd("R6 after prot", 16'h0002, 8'h04, 1'b0, arr_exp(2));
    unlock(8'hC2);
    rd("R5 unprotected", 16'h0002, 8'h02, 1'b0, 8'h00);
    unlock(8'hC2);
    rd("R5 bad pattern", 16'h0003, 8'h04, 1'b0, 8'h00);
  endtask

  task automatic t_otp();
    unlock(8'hB8);
    rd("R2 R7 row 0", 16'h0000, '0, 1'b1, otp_exp(0));
    rd("R7 row 17", 16'h0011, '0, 1'b1, otp_exp(17));
    rd("R7 row 63", 16'h003F, '0, 1'b1, otp_exp(63));
    rd("R7 row bit6 set", 16'h0045, '0, 1'b1, 8'h00);
    rd("R7 row no ee_sel", 16'h0005, '0, 1'b0, 8'h00);
    wr(16'h0555, 8'hAA);
    rd("R8 write ignored in row", 16'h0005, '0, 1'b1, otp_exp(5));
    wr(16'h0000, 8'hF0);
    rd("R8 return to normal", 16'h0005, '0, 1'b1, arr_exp(5));
  endtask

  task automatic t_abort();
    wr(16'h0555, 8'hAA);
    wr(16'h0AAA, 8'h54);
    wr(16'h0555, 8'h90);
    rd("R3 bad data", 16'h0001, 8'h01, 1'b0, arr_exp(1));
    wr(16'h0555, 8'hAA);
    wr(16'h0AAA, 8'h55);
    wr(16'h0554, 8'h90);
    rd("R3 bad cmd addr", 16'h0001, 8'h01, 1'b0, arr_exp(1));
    wr(16'h0555, 8'hAA);
    wr(16'h0000, 8'hF0);
    wr(16'h0AAA, 8'h55);
    wr(16'h0555, 8'h90);
    rd("R8 F0 mid prefix", 16'h0001, 8'h01, 1'b0, arr_exp(1));
  endtask

  task automatic t_interleave();
    wr(16'h0555, 8'hAA);
    rd("R11 read in prefix", 16'h0010, '0, 1'b0, arr_exp(16));
    wr(16'h0AAA, 8'h55);
    wr(16'h0555, 8'h90);
    rd("R11 prefix survives", 16'h0001, 8'h01, 1'b0, 8'hE3);
  endtask

  task automatic t_reset_mid();
    unlock(8'hB8);
    pulse_rst();
    rd("R10 reset leaves row", 16'h0003, '0, 1'b1, arr_exp(3));
    unlock(8'hC2);
    rd("R9 reset clears mask", 16'h0002, 8'h04, 1'b0, 8'h00);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_normal();
    t_ident();
    t_prot();
    t_otp();
    t_abort();
    t_interleave();
    t_reset_mid();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule